// File: doc/BRIEF.md
# Edge Interrupt Controller

This block turns a set of external level inputs into interrupt requests and one-clock event pulses. Each input is brought into the clock domain through a two-flop synchroniser. A registered copy of its previous value lets the block detect rising and falling edges. Every line has its own rising and falling enable, and the two are independent. A selected edge latches a sticky pending flag for that line. Software can also set a pending flag directly through a trigger register.

Lines are organised in two groups of up to 32 positions. Each group has six word registers: interrupt mask, event mask, rising enable, falling enable, software trigger and pending. The interrupt output is high while any pending flag is set and its mask bit is set. The event output pulses for a detected edge whose event-mask bit is set, and it does not depend on the pending flags. Some positions are reserved. Group 0 has no trigger or pending bits at positions 23 to 28. Group 1 has mask bits only for positions 0 to 3, and trigger and pending bits only for positions 0 and 1.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and both `irq_o` and `evt_o` are 0.
- R2: The byte offsets are as follows. Group 0 uses 0x00 interrupt mask, 0x04 event mask, 0x08 rising enable, 0x0C falling enable, 0x10 software trigger and 0x14 pending. Group 1 uses the same order at 0x18 to 0x2C. A read strobe returns its word on `bus_rdata` after the next clock edge. Offsets from 0x30 upward read 0.
- R3: A selected edge on a line sets its pending flag. If the input changes between two clock edges, the flag becomes visible after the third rising clock edge that follows.
- R4: The rising and falling enables are independent. With both set, either edge sets pending. With neither set, no edge does.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Without a write, a pending flag stays set.
- R6: If a selected edge and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R7: Writing 1 to a software trigger bit sets the pending flag at that write's clock edge. The trigger register always reads 0.
- R8: `irq_o` is 1 exactly when some pending flag has its interrupt-mask bit set. Pending flags that are masked do not raise it.
- R9: `evt_o` is high for exactly one cycle per detected edge. That cycle follows the second clock edge after the input change. The pulse occurs only when the line's event-mask bit is 1, and it occurs regardless of the pending flags and the interrupt mask.
- R10: Some bit positions are reserved. In group 0, positions 23 to 28 of the enable, trigger and pending registers read 0 and ignore writes and edges. In group 1, the masks keep only bits 0 to 3, and the enable, trigger and pending registers keep only bits 0 and 1.
- R11: `line_in[i]` for i < 32 is group 0 bit i. `line_in[32+j]` is group 1 bit j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 64 | Raw external line levels |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
The bench sweeps every line position in both groups through all four enable combinations, with one rise and one fall each. This catches a swapped edge polarity, an enable that is tied to the wrong edge, a reserved position that still latches, and a line wired to the wrong bit. It fires a write-1-to-clear on exactly the cycle in which an edge lands on the same flag. A design that gives the clear priority would lose that interrupt. Other checks target software triggers on reserved bits, writes of 0 to the pending register, and event pulses with the event mask cleared. A design that gated events on pending or mixed up the masks would pulse or stay quiet at the wrong time.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_REGS   = 6;
  localparam int NUM_GROUPS = 2;
  localparam int KIND_W     = $clog2(NUM_REGS);

  // register slot order inside a group; software decodes this order
  localparam int RK_IMASK = 0;
  localparam int RK_EMASK = 1;
  localparam int RK_RSEL  = 2;
  localparam int RK_FSEL  = 3;
  localparam int RK_SWT   = 4;
  localparam int RK_PEND  = 5;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t edge_hits(input word_t cur, input word_t prev,
                                      input word_t rsel, input word_t fsel);
    return ((cur & ~prev) & rsel) | ((~cur & prev) & fsel);
  endfunction

  // set has priority over clear
  function automatic word_t pend_next(input word_t pend, input word_t clr,
                                      input word_t set);
    return (pend & ~clr) | set;
  endfunction
endpackage

// File: rtl/eic_line_sync.sv
module eic_line_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= raw;
      lvl      <= meta_q;
      lvl_prev <= lvl;
    end
  end

  assign rise_w = lvl & ~lvl_prev;

  AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((rise_w & $past(rise_w)) == '0)); // R9
endmodule

// File: rtl/eic_group_bank.sv
module eic_group_bank
  import eic_pkg::*;
#(
  parameter word_t MASK_VALID = '1,
  parameter word_t TRIG_VALID = '1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_REGS-1:0]            wr_en,
  input  word_t                          wdata,
  input  word_t                          lvl,
  input  word_t                          lvl_prev,
  output logic [NUM_REGS-1:0][WORD_W-1:0] rd_word,
  output logic                           irq,
  output logic                           evt
);
  word_t imask, emask, rsel, fsel, pend;
  word_t hit_w, swt_w, clr_w;

  assign hit_w = edge_hits(lvl, lvl_prev, rsel, fsel) & TRIG_VALID;
  assign swt_w = wr_en[RK_SWT]  ? (wdata & TRIG_VALID) : '0;
  assign clr_w = wr_en[RK_PEND] ? (wdata & TRIG_VALID) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask <= '0;
      emask <= '0;
      rsel  <= '0;
      fsel  <= '0;
      pend  <= '0;
    end else begin
      if (wr_en[RK_IMASK]) imask <= wdata & MASK_VALID;
      if (wr_en[RK_EMASK]) emask <= wdata & MASK_VALID;
      if (wr_en[RK_RSEL])  rsel  <= wdata & TRIG_VALID;
      if (wr_en[RK_FSEL])  fsel  <= wdata & TRIG_VALID;
      pend <= pend_next(pend, clr_w, hit_w | swt_w);
    end
  end

  always_comb begin
    rd_word           = '0;
    rd_word[RK_IMASK] = imask;
    rd_word[RK_EMASK] = emask;
    rd_word[RK_RSEL]  = rsel;
    rd_word[RK_FSEL]  = fsel;
    rd_word[RK_SWT]   = '0;
    rd_word[RK_PEND]  = pend;
  end

  assign irq = |(pend & imask);
  assign evt = |(hit_w & emask);

  AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w != '0) |=> ((pend & $past(hit_w)) == $past(hit_w))); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[RK_PEND] && hit_w == '0) |=> ((pend & $past(clr_w)) == '0)); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en[RK_PEND] |=> ((pend & $past(pend)) == $past(pend))); // R5
  AST_SWT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[RK_SWT] |=> ((pend & $past(swt_w)) == $past(swt_w))); // R7
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int    ADDR_W        = 6,
  parameter word_t G0_MASK_VALID = 32'hFFFF_FFFF,
  parameter word_t G0_TRIG_VALID = 32'hE07F_FFFF,
  parameter word_t G1_MASK_VALID = 32'h0000_000F,
  parameter word_t G1_TRIG_VALID = 32'h0000_0003
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_GROUPS*WORD_W-1:0] line_in,
  input  logic                         bus_we,
  input  logic                         bus_re,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [WORD_W-1:0]            bus_wdata,
  output logic [WORD_W-1:0]            bus_rdata,
  output logic                         irq_o,
  output logic                         evt_o
);
  localparam int NUM_SLOTS = NUM_GROUPS * NUM_REGS;
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [KIND_W-1:0] kind_sel;
  logic [GRP_W-1:0]  grp_sel;
  logic              in_range;
  logic              unused_addr_lsb;

  logic [NUM_GROUPS-1:0][NUM_REGS-1:0][WORD_W-1:0] rd_all;
  logic [NUM_GROUPS-1:0][NUM_REGS-1:0]             wr_vec;
  logic [NUM_GROUPS-1:0]                           grp_irq, grp_evt;

  assign unused_addr_lsb = ^bus_addr[1:0];

  always_comb begin
    int idx;
    idx      = int'(bus_addr[ADDR_W-1:2]);
    in_range = (idx < NUM_SLOTS);
    grp_sel  = GRP_W'(idx / NUM_REGS);
    kind_sel = KIND_W'(idx % NUM_REGS);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [WORD_W-1:0] lvl, lvl_prev;

    always_comb begin
      wr_vec[g] = '0;
      if (bus_we && in_range && (int'(grp_sel) == g))
        wr_vec[g] = NUM_REGS'(1) << kind_sel;
    end

    eic_line_sync #(.W(WORD_W)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (line_in[g*WORD_W +: WORD_W]),
      .lvl      (lvl),
      .lvl_prev (lvl_prev)
    );

    eic_group_bank #(
      .MASK_VALID (g == 0 ? G0_MASK_VALID : G1_MASK_VALID),
      .TRIG_VALID (g == 0 ? G0_TRIG_VALID : G1_TRIG_VALID)
    ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_vec[g]),
      .wdata    (bus_wdata),
      .lvl      (lvl),
      .lvl_prev (lvl_prev),
      .rd_word  (rd_all[g]),
      .irq      (grp_irq[g]),
      .evt      (grp_evt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= in_range ? rd_all[grp_sel][kind_sel] : '0;
  end

  assign irq_o = |grp_irq;
  assign evt_o = |grp_evt;

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !in_range) |=> (bus_rdata == '0)); // R2
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata)); // R2
endmodule

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] line_in = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, evt_o;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [31:0] G0_TRIG = 32'hE07F_FFFF;

  always #10 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  function automatic logic [5:0] offs(input int grp, input int slot);
    return 6'((grp * 6 + slot) * 4);
  endfunction

  function automatic logic trig_exists(input int grp, input int b);
    return (grp == 0) ? (b < 23 || b > 28) : (b < 2);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] expp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 evt", 32'(evt_o), 0);
    for (int s = 0; s < 12; s++) expect_reg("R1 reg", 6'(s * 4), 0);

    // R2 / R10 layout and reserved bits
    bus_write(offs(0, 0), 32'h1234_5678);
    bus_write(offs(0, 1), 32'h0F0F_0F0F);
    expect_reg("R2 imask0", offs(0, 0), 32'h1234_5678);
    expect_reg("R2 emask0", offs(0, 1), 32'h0F0F_0F0F);
    bus_write(offs(0, 2), 32'hFFFF_FFFF);
    expect_reg("R10 rsel0", offs(0, 2), G0_TRIG);
    bus_write(offs(0, 3), 32'hFFFF_FFFF);
    expect_reg("R10 fsel0", offs(0, 3), G0_TRIG);
    bus_write(offs(1, 0), 32'hFFFF_FFFF);
    expect_reg("R10 imask1", offs(1, 0), 32'hF);
    bus_write(offs(1, 3), 32'hFFFF_FFFF);
    expect_reg("R10 fsel1", offs(1, 3), 32'h3);
    expect_reg("R2 unmapped 0x30", 6'h30, 0);
    expect_reg("R2 unmapped 0x3C", 6'h3C, 0);
    for (int s = 0; s < 12; s++) bus_write(6'(s * 4), 0);

    // R7 / R8 / R5 software trigger, masking and clearing
    bus_write(offs(0, 4), 32'h20);
    expect_reg("R7 pend after trigger", offs(0, 5), 32'h20);
    expect_reg("R7 trigger reads 0", offs(0, 4), 0);
    check("R8 masked pending no irq", 32'(irq_o), 0);
    bus_write(offs(0, 0), 32'h20);
    check("R8 unmasked irq", 32'(irq_o), 1);
    bus_write(offs(0, 0), 32'h40);
    check("R8 other mask irq", 32'(irq_o), 0);
    bus_write(offs(0, 5), 32'h0);
    expect_reg("R5 write 0 keeps", offs(0, 5), 32'h20);
    bus_write(offs(0, 5), 32'h40);
    expect_reg("R5 other bit keeps", offs(0, 5), 32'h20);
    bus_write(offs(0, 5), 32'h20);
    expect_reg("R5 write 1 clears", offs(0, 5), 0);
    bus_write(offs(0, 0), 0);
    bus_write(offs(0, 4), 32'hFFFF_FFFF);
    expect_reg("R10 trigger reserved g0", offs(0, 5), G0_TRIG);
    bus_write(offs(0, 5), 32'hFFFF_FFFF);
    expect_reg("R5 clear all g0", offs(0, 5), 0);
    bus_write(offs(1, 0), 32'h1);
    bus_write(offs(1, 4), 32'hFFFF_FFFF);
    expect_reg("R10 trigger reserved g1", offs(1, 5), 32'h3);
    check("R8 irq group1", 32'(irq_o), 1);
    bus_write(offs(1, 5), 32'h3);
    check("R8 irq drops after clear", 32'(irq_o), 0);
    bus_write(offs(1, 0), 0);

    // R6 edge and clear in the same cycle
    bus_write(offs(0, 2), 32'h8);
    bus_write(offs(0, 4), 32'h8);
    line_in[3] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_write(offs(0, 5), 32'h8);
    expect_reg("R6 edge beats clear", offs(0, 5), 32'h8);
    bus_write(offs(0, 5), 32'h8);
    expect_reg("R5 plain clear", offs(0, 5), 0);

    // R9 event gated only by event mask and edge
    line_in[3] = 1'b0;
    bus_write(offs(0, 1), 0);
    bus_write(offs(0, 5), 32'hFFFF_FFFF);
    line_in[3] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R9 no event when emask 0", 32'(evt_o), 0);
    @(posedge clk); @(negedge clk);
    expect_reg("R3 pend with emask 0", offs(0, 5), 32'h8);
    bus_write(offs(0, 1), 32'h8);
    line_in[3] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      check("R9 unselected fall no event", 32'(evt_o), 0);
    end
    for (int s = 0; s < 12; s++) bus_write(6'(s * 4), (s % 6 == 5) ? 32'hFFFF_FFFF : 0);

    // R3 R4 R9 R10 R11 sweep of every line and enable combination
    bus_write(offs(0, 1), 32'hFFFF_FFFF);
    bus_write(offs(1, 1), 32'hFFFF_FFFF);
    for (int L = 0; L < 36; L++) begin
      for (int mode = 0; mode < 4; mode++) begin
        int g, b;
        logic ok, rs, fs;
        g = L / 32; b = L % 32;
        ok = trig_exists(g, b);
        rs = mode[0]; fs = mode[1];
        bus_write(offs(g, 2), rs ? (32'h1 << b) : 0);
        bus_write(offs(g, 3), fs ? (32'h1 << b) : 0);
        bus_write(offs(g, 5), 32'hFFFF_FFFF);
        expp = 0;
        for (int step = 0; step < 2; step++) begin
          logic sel;
          sel = ok && ((step == 0) ? rs : fs);
          line_in[L] = (step == 0);
          @(posedge clk); @(negedge clk);
          @(posedge clk); @(negedge clk);
          check("R9 event on selected edge", 32'(evt_o), 32'(sel));
          @(posedge clk); @(negedge clk);
          check("R9 event one cycle", 32'(evt_o), 0);
          if (sel) expp = 32'h1 << b;
          expect_reg("R4 R11 pend after edge", offs(g, 5), expp);
          check("R8 masked no irq", 32'(irq_o), 0);
        end
        bus_write(offs(g, 2), 0);
        bus_write(offs(g, 3), 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule